// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block takes byte writes aimed at one programmable interrupt controller and works out what each write is. It has a two-location write port, chosen by a single address-select bit. It recognises the start of a four-word setup sequence and places each following word into its own register. It also drives out the settings that the rest of the controller consumes:

- the vector base,
- the cascade configuration,
- the mode word,
- the interrupt mask,
- the special-mask and status-select flags,
- the lowest-priority level.

The four setup words are mandatory and must arrive strictly in order. A command write that arrives before the sequence is complete counts as a broken setup. The block raises an error flag and keeps the controller uninitialized until a new sequence starts. Once setup is complete, writes to the odd location load the interrupt mask. Command writes to the even location then adjust the special-mask flag, the status-read source and the lowest-priority level.

A role input selects how the third setup word is used. For a master, it is an 8-bit map of the request lines that carry cascaded controllers. For a slave, its low three bits are the slave's identity.

Top module: `pic_init_seq`

## Requirements
- R1: After reset the outputs are as follows: `init_done` 0, `init_error` 0, `int_mask` 00h, vector base 0, cascade map 00h, slave id 0, mode word 00h, `spec_mask` 0, `stat_sel_service` 0 and `low_prio` 7.
- R2: An even-location write (`a0_sel`=0) with data bit 4 set is the first setup word. It is accepted in any state. On the following cycle:
  - the sequence restarts and waits for word two;
  - `init_error` and `init_done` are 0;
  - `low_prio` is 7;
  - `spec_mask` is 0;
  - `stat_sel_service` is 0, which selects the pending-request register;
  - `int_mask` is 00h.
- R3: The first odd-location write after the first setup word is word two. Only its bits [7:3] are kept, as `vec_base`.
- R4: The next odd-location write is word three. With `role_master`=1, all 8 bits go to `cascade_map`. With `role_master`=0, bits [2:0] go to `slave_id`. The register of the other role is left unchanged.
- R5: The next odd-location write is word four and is stored whole in `mode_word`. If its bit 0 is 1, `init_done` is 1 on the following cycle.
- R6: If word four has bit 0 equal to 0, `init_error` goes to 1 and `init_done` stays 0.
- R7: An even-location write with bit 4 clear is a command write. If one arrives while words two to four are awaited, or before any first word, it sets `init_error`. The block then ignores all writes other than a first word, so the mask and vector base do not change.
- R8: An odd-location write before any first setup word has been accepted since reset sets `init_error`.
- R9: After setup is complete, each odd-location write loads `int_mask` with all 8 bits, and `init_done` stays 1.
- R10: After setup is complete, a command write with bit 3 set controls two flags:
  - data[6:5]=11 sets `spec_mask` and 10 clears it;
  - data[1:0]=11 sets `stat_sel_service` (in-service register) and 10 clears it (pending-request register);
  - other codes leave each flag unchanged.
- R11: After setup is complete, a command write with bit 3 clear and data[7:5]=110 loads `low_prio` with data[2:0]. Any other such command write changes no output.
- R12: The typical setups load correctly. For a master, the sequence 11h, 08h, 04h, 01h and then mask B8h gives vector base 01h, cascade map 04h, mode 01h and mask B8h. For a slave, the sequence 11h, 70h, 02h, 01h and then mask BDh gives vector base 0Eh, slave id 2 and mask BDh.
- R13: A first setup word received while word three is awaited restarts the sequence, so the next odd-location write is taken as word two again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| a0_sel | input | 1 | Location select: 0 even, 1 odd |
| wr_data | input | 8 | Write data byte |
| role_master | input | 1 | 1 for master, 0 for slave interpretation of word three |
| vec_base | output | 5 | Vector bits [7:3] from word two |
| cascade_map | output | 8 | Master cascade-line map |
| slave_id | output | 3 | Slave identity code |
| mode_word | output | 8 | Word four as written |
| int_mask | output | 8 | Interrupt mask |
| spec_mask | output | 1 | Special mask mode flag |
| stat_sel_service | output | 1 | Status read source: 1 in-service, 0 pending-request |
| low_prio | output | 3 | Lowest-priority level |
| init_done | output | 1 | Setup complete |
| init_error | output | 1 | Setup broken or mode word invalid |

## Verification
A wrong sequence state shows up at the ports one cycle after the next write. The following odd-location byte lands in the wrong register: vector, cascade, mode or mask. Alternatively, `init_done` or `init_error` takes the wrong value. Each write is therefore followed by a full comparison of every output one cycle after its clock edge. Runs in both roles, with interrupted and faulty sequences, expose a stale or misrouted register within a single write.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;

   typedef enum logic [2:0] {
      ST_UNINIT = 3'd0,
      ST_WANT2  = 3'd1,
      ST_WANT3  = 3'd2,
      ST_WANT4  = 3'd3,
      ST_READY  = 3'd4,
      ST_FAULT  = 3'd5
   } seq_state_t;

   typedef enum logic [1:0] {
      WK_START = 2'd0,
      WK_ODD   = 2'd1,
      WK_CMD2  = 2'd2,
      WK_CMD3  = 2'd3
   } wr_kind_t;

   function automatic wr_kind_t classify(input logic a0, input logic [7:0] d);
      if (a0)        return WK_ODD;
      else if (d[4]) return WK_START;
      else if (d[3]) return WK_CMD3;
      else           return WK_CMD2;
   endfunction

endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
   import pic_init_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  wr_kind_t kind,
   input  logic     mode_ok,
   output logic     ld_w1,
   output logic     ld_w2,
   output logic     ld_w3,
   output logic     ld_w4,
   output logic     ld_mask,
   output logic     ld_cmd2,
   output logic     ld_cmd3,
   output logic     init_done,
   output logic     init_error
);

   seq_state_t state, state_nx;
   logic       err_nx;

   always_comb begin
      ld_w1   = 1'b0;
      ld_w2   = 1'b0;
      ld_w3   = 1'b0;
      ld_w4   = 1'b0;
      ld_mask = 1'b0;
      ld_cmd2 = 1'b0;
      ld_cmd3 = 1'b0;
      state_nx = state;
      err_nx   = init_error;
      if (wr_en) begin
         unique case (kind)
            WK_START: begin
               ld_w1    = 1'b1;
               state_nx = ST_WANT2;
               err_nx   = 1'b0;
            end
            WK_ODD: begin
               case (state)
                  ST_UNINIT: begin state_nx = ST_FAULT; err_nx = 1'b1; end
                  ST_WANT2:  begin ld_w2 = 1'b1; state_nx = ST_WANT3; end
                  ST_WANT3:  begin ld_w3 = 1'b1; state_nx = ST_WANT4; end
                  ST_WANT4: begin
                     ld_w4 = 1'b1;
                     if (mode_ok) state_nx = ST_READY;
                     else begin state_nx = ST_FAULT; err_nx = 1'b1; end
                  end
                  ST_READY:  ld_mask = 1'b1;
                  default:   ;
               endcase
            end
            WK_CMD2, WK_CMD3: begin
               case (state)
                  ST_UNINIT, ST_WANT2, ST_WANT3, ST_WANT4: begin
                     state_nx = ST_FAULT;
                     err_nx   = 1'b1;
                  end
                  ST_READY: begin
                     ld_cmd2 = (kind == WK_CMD2);
                     ld_cmd3 = (kind == WK_CMD3);
                  end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_UNINIT;
         init_error <= 1'b0;
      end else begin
         state      <= state_nx;
         init_error <= err_nx;
      end
   end

   assign init_done = (state == ST_READY);

   // R6: completion and error never shown together
   p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_done && init_error));

   // R7: an error only appears after a write
   p_error_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_error) |-> $past(wr_en));

   // R5: completion only follows an accepted word four
   p_done_after_word4_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> $past(ld_w4));

   // R2: a first word always clears the error on the next cycle
   p_start_clears_error_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_w1 |=> !init_error && !init_done);

endmodule

// File: rtl/pic_init_regs.sv
module pic_init_regs #(
   parameter int DATA_W        = 8,
   parameter int ID_W          = 3,
   parameter int LOW_PRIO_INIT = 7,
   localparam int VEC_W        = DATA_W - 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              role_master,
   input  logic              ld_w1,
   input  logic              ld_w2,
   input  logic              ld_w3,
   input  logic              ld_w4,
   input  logic              ld_mask,
   input  logic              ld_cmd2,
   input  logic              ld_cmd3,
   output logic [VEC_W-1:0]  vec_base,
   output logic [DATA_W-1:0] cascade_map,
   output logic [ID_W-1:0]   slave_id,
   output logic [DATA_W-1:0] mode_word,
   output logic [DATA_W-1:0] int_mask,
   output logic              spec_mask,
   output logic              stat_sel_service,
   output logic [ID_W-1:0]   low_prio
);

   localparam logic [ID_W-1:0] LP_INIT = ID_W'(LOW_PRIO_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_base         <= '0;
         cascade_map      <= '0;
         slave_id         <= '0;
         mode_word        <= '0;
         int_mask         <= '0;
         spec_mask        <= 1'b0;
         stat_sel_service <= 1'b0;
         low_prio         <= LP_INIT;
      end else begin
         if (ld_w1) begin
            int_mask         <= '0;
            spec_mask        <= 1'b0;
            stat_sel_service <= 1'b0;
            low_prio         <= LP_INIT;
         end
         if (ld_w2) vec_base <= wr_data[DATA_W-1:3];
         if (ld_w3) begin
            if (role_master) cascade_map <= wr_data;
            else             slave_id    <= wr_data[ID_W-1:0];
         end
         if (ld_w4)   mode_word <= wr_data;
         if (ld_mask) int_mask  <= wr_data;
         if (ld_cmd3) begin
            if (wr_data[6:5] == 2'b11)      spec_mask <= 1'b1;
            else if (wr_data[6:5] == 2'b10) spec_mask <= 1'b0;
            if (wr_data[1:0] == 2'b11)      stat_sel_service <= 1'b1;
            else if (wr_data[1:0] == 2'b10) stat_sel_service <= 1'b0;
         end
         if (ld_cmd2 && wr_data[7:5] == 3'b110) low_prio <= wr_data[ID_W-1:0];
      end
   end

   // R2: defaults restored by a first word
   p_start_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_w1 |=> (low_prio == LP_INIT) && !spec_mask && !stat_sel_service && (int_mask == '0));

   // R9: mask only moves on a mask load or a restart
   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_mask || ld_w1) |=> $stable(int_mask));

   // R3: vector base only moves on word two
   p_vec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_w2 |=> $stable(vec_base));

   // R4: the register of the other role is untouched by word three
   p_role_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_w3 && role_master) |=> $stable(slave_id));

   // R11: priority level only moves on restart or priority command
   p_prio_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_cmd2 || ld_w1) |=> $stable(low_prio));

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_init_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int ID_W           = 3,
   parameter int LOW_PRIO_INIT  = 7,
   parameter bit FIXED_ROLE     = 1'b0,
   parameter bit FIXED_IS_MASTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              a0_sel,
   input  logic [7:0]        wr_data,
   input  logic              role_master,
   output logic [4:0]        vec_base,
   output logic [7:0]        cascade_map,
   output logic [2:0]        slave_id,
   output logic [7:0]        mode_word,
   output logic [7:0]        int_mask,
   output logic              spec_mask,
   output logic              stat_sel_service,
   output logic [2:0]        low_prio,
   output logic              init_done,
   output logic              init_error
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("pic_init_seq: DATA_W must be 8");
      end
      if (ID_W != 3) begin : g_bad_id
         $error("pic_init_seq: ID_W must be 3");
      end
      if (LOW_PRIO_INIT < 0 || LOW_PRIO_INIT >= (1 << ID_W)) begin : g_bad_prio
         $error("pic_init_seq: LOW_PRIO_INIT out of range");
      end
   endgenerate

   logic role_eff;
   generate
      if (FIXED_ROLE) begin : g_role_fixed
         assign role_eff = FIXED_IS_MASTER;
      end else begin : g_role_pin
         assign role_eff = role_master;
      end
   endgenerate

   wr_kind_t kind;
   logic ld_w1, ld_w2, ld_w3, ld_w4, ld_mask, ld_cmd2, ld_cmd3;

   assign kind = classify(a0_sel, wr_data);

   pic_init_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .kind       (kind),
      .mode_ok    (wr_data[0]),
      .ld_w1      (ld_w1),
      .ld_w2      (ld_w2),
      .ld_w3      (ld_w3),
      .ld_w4      (ld_w4),
      .ld_mask    (ld_mask),
      .ld_cmd2    (ld_cmd2),
      .ld_cmd3    (ld_cmd3),
      .init_done  (init_done),
      .init_error (init_error)
   );

   pic_init_regs #(
      .DATA_W        (DATA_W),
      .ID_W          (ID_W),
      .LOW_PRIO_INIT (LOW_PRIO_INIT)
   ) u_regs (
      .clk              (clk),
      .rst_n            (rst_n),
      .wr_data          (wr_data),
      .role_master      (role_eff),
      .ld_w1            (ld_w1),
      .ld_w2            (ld_w2),
      .ld_w3            (ld_w3),
      .ld_w4            (ld_w4),
      .ld_mask          (ld_mask),
      .ld_cmd2          (ld_cmd2),
      .ld_cmd3          (ld_cmd3),
      .vec_base         (vec_base),
      .cascade_map      (cascade_map),
      .slave_id         (slave_id),
      .mode_word        (mode_word),
      .int_mask         (int_mask),
      .spec_mask        (spec_mask),
      .stat_sel_service (stat_sel_service),
      .low_prio         (low_prio)
   );

   // R8: a mask load never happens while uninitialized
   p_mask_only_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a0_sel && !init_done) |=> $stable(int_mask));

endmodule

// File: tb/pic_init_seq_tb.sv
module pic_init_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       a0_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       role_master = 1'b1;
   logic [4:0] vec_base;
   logic [7:0] cascade_map;
   logic [2:0] slave_id;
   logic [7:0] mode_word;
   logic [7:0] int_mask;
   logic       spec_mask;
   logic       stat_sel_service;
   logic [2:0] low_prio;
   logic       init_done;
   logic       init_error;

   always #2.5 clk = ~clk;

   pic_init_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0_sel(a0_sel), .wr_data(wr_data),
      .role_master(role_master), .vec_base(vec_base), .cascade_map(cascade_map),
      .slave_id(slave_id), .mode_word(mode_word), .int_mask(int_mask),
      .spec_mask(spec_mask), .stat_sel_service(stat_sel_service), .low_prio(low_prio),
      .init_done(init_done), .init_error(init_error)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // expectation model built from the requirements
   localparam int M_UN = 0, M_W2 = 1, M_W3 = 2, M_W4 = 3, M_RD = 4, M_FL = 5;
   int       m_st = M_UN;
   logic     e_err = 0, e_smm = 0, e_isr = 0;
   logic [4:0] e_vec = 0;
   logic [7:0] e_cas = 0, e_mode = 0, e_mask = 0;
   logic [2:0] e_id = 0, e_lp = 3'd7;

   logic [38:0] exp_q[$];
   string       tag_q[$];

   function automatic logic [38:0] exp_snap();
      return {(m_st == M_RD), e_err, e_vec, e_cas, e_id, e_mode, e_mask, e_smm, e_isr, e_lp};
   endfunction

   function automatic logic [38:0] act_snap();
      return {init_done, init_error, vec_base, cascade_map, slave_id, mode_word,
              int_mask, spec_mask, stat_sel_service, low_prio};
   endfunction

   task automatic model(input logic a0, input logic [7:0] d);
      if (!a0 && d[4]) begin
         m_st = M_W2; e_err = 0; e_lp = 3'd7; e_smm = 0; e_isr = 0; e_mask = 0;
      end else if (a0) begin
         case (m_st)
            M_UN: begin m_st = M_FL; e_err = 1; end
            M_W2: begin e_vec = d[7:3]; m_st = M_W3; end
            M_W3: begin
               if (role_master) e_cas = d; else e_id = d[2:0];
               m_st = M_W4;
            end
            M_W4: begin
               e_mode = d;
               if (d[0]) m_st = M_RD; else begin m_st = M_FL; e_err = 1; end
            end
            M_RD: e_mask = d;
            default: ;
         endcase
      end else begin
         if (m_st <= M_W4) begin m_st = M_FL; e_err = 1; end
         else if (m_st == M_RD) begin
            if (d[3]) begin
               if (d[6:5] == 2'b11) e_smm = 1; else if (d[6:5] == 2'b10) e_smm = 0;
               if (d[1:0] == 2'b11) e_isr = 1; else if (d[1:0] == 2'b10) e_isr = 0;
            end else if (d[7:5] == 3'b110) e_lp = d[2:0];
         end
      end
   endtask

   // driver: one write, expectation queued for the monitor
   task automatic wr(input logic a0, input logic [7:0] d, input string tag);
      @(negedge clk);
      wr_en = 1'b1; a0_sel = a0; wr_data = d;
      model(a0, d);
      exp_q.push_back(exp_snap());
      tag_q.push_back(tag);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // monitor: compare every output one cycle after each write edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [38:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (act_snap() !== e) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", t, act_snap(), e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_cmp++;
      if (act_snap() !== exp_snap()) begin
         n_bad++;
         $display("FAIL R1 reset: actual %h expected %h", act_snap(), exp_snap());
      end

      wr(1'b1, 8'h55, "R8 odd before start");
      wr(1'b1, 8'hAA, "R7 odd ignored in fault");

      role_master = 1'b1;
      wr(1'b0, 8'h11, "R2 first word master");
      wr(1'b1, 8'h08, "R3 R12 vector master");
      wr(1'b1, 8'h04, "R4 R12 cascade map");
      wr(1'b1, 8'h01, "R5 R12 mode word");
      wr(1'b1, 8'hB8, "R9 R12 mask master");
      wr(1'b1, 8'h3C, "R9 second mask");
      wr(1'b0, 8'h6B, "R10 set special and service");
      wr(1'b0, 8'h4A, "R10 clear special and service");
      wr(1'b0, 8'h08, "R10 no-op codes");
      wr(1'b0, 8'hC5, "R11 priority load");
      wr(1'b0, 8'h20, "R11 other command no effect");

      wr(1'b0, 8'h11, "R2 restart clears");
      wr(1'b1, 8'h50, "R3 vector again");
      wr(1'b0, 8'h13, "R13 restart during word three");
      wr(1'b1, 8'h70, "R13 word two again");
      wr(1'b0, 8'h0A, "R7 command in sequence");
      wr(1'b1, 8'hFF, "R7 odd ignored after break");

      role_master = 1'b0;
      wr(1'b0, 8'h11, "R2 first word slave");
      wr(1'b1, 8'h70, "R12 vector slave");
      wr(1'b1, 8'h02, "R4 R12 slave id");
      wr(1'b1, 8'h01, "R5 slave mode");
      wr(1'b1, 8'hBD, "R12 mask slave");

      wr(1'b0, 8'h11, "R2 restart for bad mode");
      wr(1'b1, 8'h08, "R3 vector");
      wr(1'b1, 8'h05, "R4 slave id 5");
      wr(1'b1, 8'h00, "R6 mode bit0 clear");
      wr(1'b1, 8'h77, "R6 odd ignored after bad mode");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule